// File: doc/BRIEF.md
# DMA Bus Command Selector

A script-driven DMA engine requests one bus cycle at a time. For each request this block chooses the 4-bit bus command code and a flag that says whether the address is in I/O space or memory space. The choice depends on the kind of cycle: an instruction (opcode) fetch, a data read or a data write. It also depends on whether the access targets a move destination, and on four control bits. Those bits are a destination I/O-space select, a read-line enable, a read-multiple enable and a cache-mode enable. A per-request flag tells the block whether a multiple-line read is legal for this burst.

The engine offers a request with `req_valid` while `req_ready` is high. On the accepting edge the block latches the command and the space flag. It presents them with `cmd_valid` until the bus side pulses `cmd_done`. Changes on the request inputs during that time have no effect. Cycle-type encoding: 2'b00 opcode fetch, 2'b01 data read, 2'b10 data write, 2'b11 data read (handled exactly like 2'b01).

Top module: `dma_cmd_select`

## Requirements
- R1: While reset is asserted and after it is released, `cmd_valid` is 0 and `req_ready` is 1.
- R2: A data write (cycle 2'b10) with `req_dest`=1 and `cfg_dest_io`=1 produces I/O Write, code 4'b0011, with `cmd_io`=1.
- R3: Any other data write (destination in memory space, or not a destination access) produces Memory Write, code 4'b0111, with `cmd_io`=0.
- R4: An opcode fetch (cycle 2'b00) always produces Memory Read 4'b0110. It never produces Read Line 4'b1110, whatever the read enables, cache mode and legality flag say.
- R5: A data read (cycle 2'b01 or 2'b11) with `cfg_rd_mult_en`=1, `cfg_cache_en`=1 and `req_burst_legal`=1 produces Read Multiple 4'b1100. This holds even when read-line is also enabled.
- R6: A data read for which R5 does not apply, with `cfg_rd_line_en`=1, produces Read Line 4'b1110.
- R7: A data read with neither R5 nor R6 applying produces Memory Read 4'b0110. In particular, read-multiple enable has no effect while cache mode is off.
- R8: Reads and opcode fetches always report `cmd_io`=0. The destination flag and the I/O select have no effect on them.
- R9: When `req_valid`=1 and `req_ready`=1 at a rising edge, the next cycle shows `cmd_valid`=1 and `req_ready`=0, with the command chosen from the inputs at that edge.
- R10: While `cmd_valid`=1, `cmd_code` and `cmd_io` hold their latched values. New requests and changes on any request or control input are ignored.
- R11: A rising edge with `cmd_valid`=1 and `cmd_done`=1 makes `cmd_valid`=0 and `req_ready`=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Engine offers a bus cycle |
| req_ready | output | 1 | Block can accept a request |
| req_cycle | input | 2 | Cycle type: 00 fetch, 01/11 data read, 10 data write |
| req_dest | input | 1 | Access targets the move destination |
| req_burst_legal | input | 1 | Multiple-line read is legal for this burst |
| cfg_dest_io | input | 1 | Destination lies in I/O space |
| cfg_rd_line_en | input | 1 | Enable Read Line for non-fetch reads |
| cfg_rd_mult_en | input | 1 | Enable Read Multiple |
| cfg_cache_en | input | 1 | Cache mode on |
| cmd_valid | output | 1 | Latched command is being presented |
| cmd_code | output | 4 | Bus command code |
| cmd_io | output | 1 | 1 = I/O space, 0 = memory space |
| cmd_done | input | 1 | Bus side has finished the cycle |

## Verification
The bench builds the block with its default parameters: a 4-bit command and a 2-bit cycle type. With these values the eight decision inputs form only 256 combinations, so every one is driven, including the reserved cycle code and every mix of enable, cache and legality bits. The hold time before `cmd_done` varies from zero to two extra cycles. On some requests `req_valid` stays high while the block is busy. The bench also scrambles every request and control input during the hold, so the stability and ignore rules are exercised on every vector.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int CMD_W = 4;
  localparam int CYC_W = 2;

  typedef enum logic [CYC_W-1:0] {
    CYC_FETCH    = 2'b00,
    CYC_READ     = 2'b01,
    CYC_WRITE    = 2'b10,
    CYC_READ_ALT = 2'b11
  } cyc_e;

  localparam logic [CMD_W-1:0] CMD_IO_WR    = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_MEM_RD   = 4'b0110;
  localparam logic [CMD_W-1:0] CMD_MEM_WR   = 4'b0111;
  localparam logic [CMD_W-1:0] CMD_RD_MULT  = 4'b1100;
  localparam logic [CMD_W-1:0] CMD_RD_LINE  = 4'b1110;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
(
  input  logic [CYC_W-1:0] cyc,
  input  logic             dest,
  input  logic             burst_legal,
  input  logic             dest_io,
  input  logic             rd_line_en,
  input  logic             rd_mult_en,
  input  logic             cache_en,
  output logic [CMD_W-1:0] code,
  output logic             io_space
);
  logic is_fetch;
  logic is_write;
  logic mult_ok;

  always_comb begin
    is_fetch = (cyc == CYC_FETCH);
    is_write = (cyc == CYC_WRITE);
    mult_ok  = rd_mult_en && cache_en && burst_legal;
  end

  always_comb begin
    code     = CMD_MEM_RD;
    io_space = 1'b0;
    if (is_write) begin
      if (dest && dest_io) begin
        code     = CMD_IO_WR;
        io_space = 1'b1;
      end else begin
        code = CMD_MEM_WR;
      end
    end else if (!is_fetch) begin
      if (mult_ok)         code = CMD_RD_MULT;
      else if (rd_line_en) code = CMD_RD_LINE;
      else                 code = CMD_MEM_RD;
    end
  end
endmodule

// File: rtl/dma_cmd_hold.sv
module dma_cmd_hold #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_done
);
  logic         busy_q, busy_d;
  logic         load_en;
  logic [W-1:0] data_q;

  always_comb begin
    load_en = in_valid && !busy_q;
    if (busy_q) busy_d = !out_done;
    else        busy_d = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= in_data;
  end

  assign in_ready  = !busy_q;
  assign out_valid = busy_q;
  assign out_data  = data_q;

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && !in_ready && out_data == $past(in_data));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_done |=> out_valid && $stable(out_data));

  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_done |=> !out_valid && in_ready);
endmodule

// File: rtl/dma_cmd_select.sv
module dma_cmd_select
  import dma_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CYC_W-1:0] req_cycle,
  input  logic             req_dest,
  input  logic             req_burst_legal,
  input  logic             cfg_dest_io,
  input  logic             cfg_rd_line_en,
  input  logic             cfg_rd_mult_en,
  input  logic             cfg_cache_en,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_code,
  output logic             cmd_io,
  input  logic             cmd_done
);
  localparam int PW = CMD_W + 1;

  logic [CMD_W-1:0] dec_code;
  logic             dec_io;
  logic [PW-1:0]    held;

  dma_cmd_decode u_decode (
    .cyc         (req_cycle),
    .dest        (req_dest),
    .burst_legal (req_burst_legal),
    .dest_io     (cfg_dest_io),
    .rd_line_en  (cfg_rd_line_en),
    .rd_mult_en  (cfg_rd_mult_en),
    .cache_en    (cfg_cache_en),
    .code        (dec_code),
    .io_space    (dec_io)
  );

  dma_cmd_hold #(.W(PW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   ({dec_io, dec_code}),
    .out_valid (cmd_valid),
    .out_data  (held),
    .out_done  (cmd_done)
  );

  assign cmd_io   = held[PW-1];
  assign cmd_code = held[CMD_W-1:0];

  // R4
  fetch_no_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_cycle == CYC_FETCH |-> dec_code == CMD_MEM_RD);

  // R8
  io_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_io |-> cmd_code == CMD_IO_WR);

  // R5
  mult_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_cycle[0] && cfg_rd_mult_en && cfg_cache_en && req_burst_legal |-> dec_code == CMD_RD_MULT);
endmodule

// File: tb/tb_dma_cmd_select.sv
`timescale 1ns/100ps
module tb_dma_cmd_select;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_cycle;
  logic       req_dest, req_burst_legal;
  logic       cfg_dest_io, cfg_rd_line_en, cfg_rd_mult_en, cfg_cache_en;
  logic       cmd_valid, cmd_io, cmd_done;
  logic [3:0] cmd_code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_cmd_select dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cycle(req_cycle), .req_dest(req_dest), .req_burst_legal(req_burst_legal),
    .cfg_dest_io(cfg_dest_io), .cfg_rd_line_en(cfg_rd_line_en),
    .cfg_rd_mult_en(cfg_rd_mult_en), .cfg_cache_en(cfg_cache_en),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_io(cmd_io), .cmd_done(cmd_done)
  );

  // Behavioural reference: expected code, space and requirement tag
  function automatic int ref_code(input logic [1:0] c, input logic d, input logic lg,
                                  input logic dio, input logic rl, input logic rm, input logic ce);
    if (c == 2'd2) return (d & dio) ? 3 : 7;
    if (c == 2'd0) return 6;
    if (rm & ce & lg) return 12;
    if (rl) return 14;
    return 6;
  endfunction

  function automatic string ref_tag(input logic [1:0] c, input int code);
    if (c == 2'd0) return "R4";
    if (code == 3)  return "R2";
    if (code == 7)  return "R3";
    if (code == 12) return "R5";
    if (code == 14) return "R6";
    return "R7";
  endfunction

  logic  m_valid;
  int    m_code;
  logic  m_io;
  string m_tag;
  int    m_age;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_code <= 0; m_io <= 1'b0; m_tag <= "R1"; m_age <= 0;
    end else if (m_valid) begin
      m_age <= m_age + 1;
      if (cmd_done) m_valid <= 1'b0;
    end else if (req_valid) begin
      m_valid <= 1'b1;
      m_age   <= 0;
      m_code  <= ref_code(req_cycle, req_dest, req_burst_legal, cfg_dest_io,
                          cfg_rd_line_en, cfg_rd_mult_en, cfg_cache_en);
      m_io    <= (req_cycle == 2'd2) && req_dest && cfg_dest_io;
      m_tag   <= ref_tag(req_cycle, ref_code(req_cycle, req_dest, req_burst_legal,
                          cfg_dest_io, cfg_rd_line_en, cfg_rd_mult_en, cfg_cache_en));
    end
  end

  logic prev_valid = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1: reset state
      checks++;
      if (cmd_valid !== 1'b0 || req_ready !== 1'b1) begin
        errors++;
        $display("FAIL R1 reset: valid=%b ready=%b expected valid=0 ready=1", cmd_valid, req_ready);
      end
    end else begin
      checks++;
      if (cmd_valid !== m_valid || req_ready !== !m_valid) begin
        errors++;
        $display("FAIL %s handshake: valid=%b ready=%b expected valid=%b ready=%b",
                 prev_valid ? "R11" : "R9", cmd_valid, req_ready, m_valid, !m_valid);
      end
      if (m_valid) begin
        checks++;
        if (int'(cmd_code) != m_code || cmd_io !== m_io) begin
          errors++;
          $display("FAIL %s command: code=%b io=%b expected code=%b io=%b",
                   (m_age > 0) ? "R10" : m_tag, cmd_code, cmd_io, 4'(m_code), m_io);
        end
        // R8: reads and fetches stay in memory space
        if (m_code != 3) begin
          checks++;
          if (cmd_io !== 1'b0) begin
            errors++;
            $display("FAIL R8 space: io=%b expected 0", cmd_io);
          end
        end
      end
    end
    prev_valid = m_valid;
  end

  task automatic set_inputs(input int v);
    req_cycle       = v[1:0];
    req_dest        = v[2];
    req_burst_legal = v[3];
    cfg_dest_io     = v[4];
    cfg_rd_line_en  = v[5];
    cfg_rd_mult_en  = v[6];
    cfg_cache_en    = v[7];
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; cmd_done = 1'b0;
    set_inputs(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      set_inputs(v);
      req_valid = 1'b1;
      @(negedge clk);
      // R10: scramble everything while the command is held
      set_inputs(~v);
      req_valid = (v % 4 == 0);
      repeat (v % 3) @(negedge clk);
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done  = 1'b0;
      req_valid = 1'b0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule